// File: doc/BRIEF.md
# Hibernate Wakeup and Reset Sequencer

This block runs in the slow always-on clock domain and decides when the rest of the chip is powered. Software writes a one to the hibernate register, and the block drops its power-enable output and holds the chip's reset output low. While the chip is powered down, the block watches a wakeup pin. The pin counts as a wakeup only after it has stayed high for a programmable number of clock ticks, so short glitches are rejected. Once a wakeup is accepted, power-enable returns at once. The reset output then stays low for a second programmable tick count before it releases.

Both tick counts come from coarse bit fields. Each field holds a multiple of 2^GRAIN_LOG2 ticks. The register bits below and above each field are ignored. With the default parameters the filter field is bits 15:5 and the hold field is bits 11:5. At a 32 kHz clock this gives a filter range of about 0 to 2 s and a reset hold range of about 0 to 125 ms. The internal states are RUN, HIBERNATE, FILTER and RESET_HOLD.

Top module: `pws_top`

## Requirements
- R1: After reset the block is in RUN, with pwr_en = 1 and rst_out_n = 1. Both count fields reset to zero.
- R2: In RUN, a write with bit 0 = 1 to offset 0x20 moves the block to HIBERNATE at that clock edge. From then on pwr_en = 0 and rst_out_n = 0.
- R3: Some writes have no effect on the outputs:
  - a write to offset 0x20 with bit 0 = 0;
  - a write to an offset that is not 0x20, 0x24 or 0x28.
- R4: A write to offset 0x24 sets the filter count N. N is the value of data bits [GRAIN_LOG2+FILT_W-1 : GRAIN_LOG2] multiplied by 2^GRAIN_LOG2. All other data bits are ignored.
- R5: A write to offset 0x28 sets the reset hold count H. H is the value of data bits [GRAIN_LOG2+HOLD_W-1 : GRAIN_LOG2] multiplied by 2^GRAIN_LOG2. All other data bits are ignored.
- R6: While powered down, a wakeup is accepted at the clock edge where wake_pin has been sampled high on max(N,1) consecutive edges. pwr_en rises just after that edge. A count of zero therefore gives an immediate transition.
- R7: If wake_pin is sampled low before the count is reached, the filter count restarts. A later wakeup then needs the full max(N,1) consecutive high samples again, and the low sample itself never raises pwr_en.
- R8: After pwr_en rises, rst_out_n stays low for exactly H more clock edges and then goes high (RESET_HOLD returns to RUN). When H = 0, rst_out_n rises together with pwr_en.
- R9: Hibernate writes made while the block is not in RUN are ignored. In particular, a hibernate write during the reset hold neither cuts power nor changes when reset is released.
- R10: rst_out_n is never high while pwr_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | 32 | Write data |
| wake_pin | input | 1 | Wakeup request pin, active high |
| pwr_en | output | 1 | Power enable for the switched domain |
| rst_out_n | output | 1 | Active-low reset for the switched domain |

## Verification
The bench builds the block with GRAIN_LOG2 = 2, FILT_W = 3 and HOLD_W = 2. The filter field then sits in bits 4:2 and the hold field in bits 3:2, so every filter value (0 to 28 ticks) can be paired with every hold value (0 to 12 ticks) in a full sweep. In that sweep the zero-count corner cases come up naturally, and each register write also sets the bits on both sides of its field. The short counts also make a glitch one tick before acceptance cheap to test, along with a hibernate write placed inside a live reset hold.

// File: rtl/pws_pkg.sv
package pws_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HIB    = 2'd1,
        ST_FILT   = 2'd2,
        ST_HOLD   = 2'd3
    } pws_state_t;

    localparam logic [7:0] OFS_HIBERNATE = 8'h20;
    localparam logic [7:0] OFS_FILTER    = 8'h24;
    localparam logic [7:0] OFS_HOLD      = 8'h28;
endpackage

// File: rtl/pws_regs.sv
module pws_regs
    import pws_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int GRAIN_LOG2 = 5,
    parameter int FILT_W     = 11,
    parameter int HOLD_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic [FILT_W-1:0] filt_field,
    output logic [HOLD_W-1:0] hold_field,
    output logic              hib_req
);
    typedef struct packed {
        logic [FILT_W-1:0] filt;
        logic [HOLD_W-1:0] hold;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        hib_req = 1'b0;
        if (wr_en) begin
            if (wr_addr == ADDR_W'(OFS_FILTER))
                r_d.filt = wr_data[GRAIN_LOG2 +: FILT_W];
            if (wr_addr == ADDR_W'(OFS_HOLD))
                r_d.hold = wr_data[GRAIN_LOG2 +: HOLD_W];
            if (wr_addr == ADDR_W'(OFS_HIBERNATE))
                hib_req = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign filt_field = r_q.filt;
    assign hold_field = r_q.hold;
endmodule

// File: rtl/pws_fsm.sv
module pws_fsm
    import pws_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hib_req,
    input  logic             wake_pin,
    input  logic [CNT_W-1:0] filt_ticks,
    input  logic [CNT_W-1:0] hold_ticks,
    output pws_state_t       state
);
    typedef struct packed {
        pws_state_t       st;
        logic [CNT_W-1:0] cnt;
    } fsm_t;

    fsm_t f_d, f_q;
    logic [CNT_W:0] cnt_inc;
    logic           accept;

    always_comb begin
        f_d     = f_q;
        accept  = 1'b0;
        cnt_inc = {1'b0, f_q.cnt} + (CNT_W+1)'(1);
        case (f_q.st)
            ST_RUN: begin
                if (hib_req) begin
                    f_d.st  = ST_HIB;
                    f_d.cnt = '0;
                end
            end
            ST_HIB: begin
                if (wake_pin) begin
                    if (filt_ticks <= CNT_W'(1)) begin
                        accept = 1'b1;
                    end else begin
                        f_d.st  = ST_FILT;
                        f_d.cnt = CNT_W'(1);
                    end
                end
            end
            ST_FILT: begin
                if (!wake_pin) begin
                    f_d.st  = ST_HIB;
                    f_d.cnt = '0;
                end else if (cnt_inc >= {1'b0, filt_ticks}) begin
                    accept = 1'b1;
                end else begin
                    f_d.cnt = cnt_inc[CNT_W-1:0];
                end
            end
            default: begin
                if (cnt_inc >= {1'b0, hold_ticks}) begin
                    f_d.st  = ST_RUN;
                    f_d.cnt = '0;
                end else begin
                    f_d.cnt = cnt_inc[CNT_W-1:0];
                end
            end
        endcase
        if (accept) begin
            f_d.st  = (hold_ticks == '0) ? ST_RUN : ST_HOLD;
            f_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_RUN, cnt: '0};
        else        f_q <= f_d;
    end

    assign state = f_q.st;
endmodule

// File: rtl/pws_top.sv
module pws_top
    import pws_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int GRAIN_LOG2 = 5,
    parameter int FILT_W     = 11,
    parameter int HOLD_W     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              wake_pin,
    output logic              pwr_en,
    output logic              rst_out_n
);
    localparam int FIELD_MAX = (FILT_W > HOLD_W) ? FILT_W : HOLD_W;
    localparam int CNT_W     = FIELD_MAX + GRAIN_LOG2;

    logic [FILT_W-1:0] filt_field;
    logic [HOLD_W-1:0] hold_field;
    logic              hib_req;
    logic [CNT_W-1:0]  filt_ticks;
    logic [CNT_W-1:0]  hold_ticks;
    pws_state_t        state;

    pws_regs #(
        .ADDR_W(ADDR_W), .GRAIN_LOG2(GRAIN_LOG2),
        .FILT_W(FILT_W), .HOLD_W(HOLD_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .filt_field(filt_field), .hold_field(hold_field),
        .hib_req(hib_req)
    );

    // Coarse fields scaled to ticks: low grain bits are zero.
    assign filt_ticks = CNT_W'({filt_field, {GRAIN_LOG2{1'b0}}});
    assign hold_ticks = CNT_W'({hold_field, {GRAIN_LOG2{1'b0}}});

    pws_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hib_req(hib_req), .wake_pin(wake_pin),
        .filt_ticks(filt_ticks), .hold_ticks(hold_ticks), .state(state)
    );

    assign pwr_en    = (state == ST_RUN) || (state == ST_HOLD);
    assign rst_out_n = (state == ST_RUN);
endmodule

// File: rtl/pws_chk.sv
module pws_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              wake_pin,
    input logic              pwr_en,
    input logic              rst_out_n
);
    // R2: hibernate write while running cuts power next cycle
    a_r2_enter_hib: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_W'(8'h20) && wr_data[0] && pwr_en && rst_out_n)
        |=> !pwr_en);

    // R3: power only falls after a write
    a_r3_fall_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> $past(wr_en));

    // R6: power only returns on an edge with the pin high
    a_r6_rise_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_en) |-> $past(wake_pin));

    // R7: a low pin sample while powered down keeps power off
    a_r7_low_pin_stays_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_en && !wake_pin) |=> !pwr_en);

    // R8: reset release only with power on
    a_r8_release_powered: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out_n) |-> pwr_en);

    // R10: reset held while unpowered
    a_r10_off_means_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |-> !rst_out_n);
endmodule

bind pws_top pws_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wake_pin(wake_pin), .pwr_en(pwr_en),
    .rst_out_n(rst_out_n)
);

// File: tb/sim_pws_top.sv
module sim_pws_top;
    localparam int G  = 2;
    localparam int FW = 3;
    localparam int HW = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wake_pin = 1'b0;
    logic        pwr_en, rst_out_n;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    pws_top #(.ADDR_W(8), .GRAIN_LOG2(G), .FILT_W(FW), .HOLD_W(HW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wake_pin(wake_pin), .pwr_en(pwr_en),
        .rst_out_n(rst_out_n)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    // Counts edges until pwr_en rises; wake_pin held high.
    task automatic edges_to_power(output int k);
        k = 0;
        wake_pin = 1'b1;
        while (!pwr_en && k < 100) begin
            tick();
            k++;
        end
        wake_pin = 1'b0;
    endtask

    task automatic edges_to_release(output int k);
        k = 0;
        while (!rst_out_n && k < 100) begin
            tick();
            k++;
        end
    endtask

    initial begin
        int k;
        int k2;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pwr_en", int'(pwr_en), 1);
        check("R1 rst_out_n", int'(rst_out_n), 1);

        // R1: fields reset to zero, so a one-sample wake restores at once
        wr(8'h20, 32'h1);
        check("R2 pwr_en after hib write", int'(pwr_en), 0);
        check("R2 rst_out_n after hib write", int'(rst_out_n), 0);
        edges_to_power(k);
        check("R1 zero filter default", k, 1);
        check("R1 zero hold default", int'(rst_out_n), 1);

        // R3: ignored writes
        wr(8'h20, 32'hFFFF_FFFE);
        check("R3 bit0 clear", int'(pwr_en), 1);
        wr(8'h2C, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        tick();
        check("R3 unmapped pwr_en", int'(pwr_en), 1);
        check("R3 unmapped rst_out_n", int'(rst_out_n), 1);

        // R4 R5 R6 R8: full sweep; junk set around each field
        for (int fv = 0; fv < (1 << FW); fv++) begin
            for (int hv = 0; hv < (1 << HW); hv++) begin
                int n_exp;
                wr(8'h24, (32'(fv) << G) | 32'h3 | (32'h1 << (G + FW)) | 32'h8000_0000);
                wr(8'h28, (32'(hv) << G) | 32'h3 | (32'h1 << (G + HW)) | 32'h0000_0080);
                wr(8'h20, 32'h1);
                check("R2 entered", int'(pwr_en), 0);
                n_exp = (fv << G);
                if (n_exp < 1) n_exp = 1;
                edges_to_power(k);
                check("R4 R6 filter edges", k, n_exp);
                edges_to_release(k2);
                check("R5 R8 hold edges", k2, hv << G);
            end
        end

        // R7: glitch one sample before acceptance, then full count again
        wr(8'h24, 32'(3) << G);
        wr(8'h28, 32'(0));
        wr(8'h20, 32'h1);
        wake_pin = 1'b1;
        for (int i = 0; i < (3 << G) - 1; i++) tick();
        wake_pin = 1'b0;
        tick();
        check("R7 glitch rejected", int'(pwr_en), 0);
        tick();
        check("R7 still off", int'(pwr_en), 0);
        edges_to_power(k);
        check("R7 reload full count", k, 3 << G);

        // R9: hibernate write during reset hold ignored
        wr(8'h24, 32'(0));
        wr(8'h28, 32'(3) << G);
        wr(8'h20, 32'h1);
        edges_to_power(k);
        check("R9 powered", int'(pwr_en), 1);
        wr(8'h20, 32'h1);
        check("R9 hib write in hold keeps power", int'(pwr_en), 1);
        edges_to_release(k2);
        check("R9 release timing unchanged", k2 + 1, 3 << G);
        check("R10 released with power", int'(pwr_en), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule